// File: doc/BRIEF.md
# Subcode Q Frame Capture and Serial Readout

This block collects the Q-channel bit carried by each demodulated subcode symbol, one bit per accepted symbol, and groups the bits into frames delimited by a sync mark. When a frame ends, the block validates the 16-bit check word against the 80 payload bits. If the host is not in the middle of a read, the frame is copied into a readout register. The host then clocks the payload out serially on its own readout clock, which is resynchronized into the system clock domain.

Symbols arrive on a valid/ready stream. The block never applies back-pressure: ready is held high, and every symbol offered with valid set is taken in that cycle. The only exception is a symbol offered in a sync-mark cycle, which is the sync symbol itself and is dropped. The status outputs are plain levels or pulses. They include a CRC-good flag, a one-cycle frame-ready pulse, and a confirmed flag. The confirmed flag rises when two consecutive good frames carry identical payloads.

Top module: `subq_frame_reader`

## Requirements
- R1: `sym_ready` is always 1. A symbol with `sym_valid` high is appended to the current frame, except in a cycle where `sync_mark` is high, in which case the symbol is discarded.
- R2: A frame is 96 bits. The first 80 bits are payload, with the first-arriving bit treated as the most significant. The last 16 bits are the bitwise inverse of a CRC over the payload, computed with polynomial x^16+x^12+x^5+1 (0x1021), an all-zero start value, and payload bits taken in arrival order.
- R3: A boundary is a `sync_mark` cycle in which at least one bit has been collected since the previous sync mark. A sync mark with nothing collected is ignored. A boundary frame is good only if exactly 96 bits were collected and the check word matches.
- R4: At a boundary while no read is in progress, `q_crc_ok` takes the frame's good/bad result, and a good frame is loaded into the readout register. `q_crc_ok` changes only at boundaries.
- R5: `q_ready_pulse` is high for exactly the one cycle after a boundary that loaded a good frame.
- R6: After a load, `q_sdata` shows payload bit 79. Each rising edge of `host_sclk`, sampled through a two-flop synchronizer, presents the next lower bit on the third system clock edge after the rise. After 80 edges the read is complete, `q_sdata` is 0, and further edges are ignored.
- R7: A read is in progress when 1 to 79 edges have been taken since the last load. A boundary during a read loads nothing and leaves `q_crc_ok` unchanged, and the read continues with the old payload intact.
- R8: If a boundary that would load and a synchronized host edge act in the same cycle, the load wins and that edge is dropped. During a read, the edge is applied and the load is skipped.
- R9: `q_sdata` is 0 whenever `q_crc_ok` is 0.
- R10: At each boundary, `q_confirmed` is set if the frame is good, the previous boundary's frame was also good, and both payloads are equal. Any other boundary clears it, whether or not a read is in progress.
- R11: Reset clears `q_crc_ok`, `q_confirmed`, `q_ready_pulse`, `q_sdata` and all held frames.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sym_valid | input | 1 | Subcode symbol offered |
| sym_ready | output | 1 | Symbol accepted (always 1) |
| sym_qbit | input | 1 | Q-channel bit of the offered symbol |
| sync_mark | input | 1 | Subcode frame sync indication |
| host_sclk | input | 1 | Host readout clock (asynchronous) |
| q_sdata | output | 1 | Serial payload bit, MSB first |
| q_crc_ok | output | 1 | Held payload passed its CRC |
| q_ready_pulse | output | 1 | One-cycle pulse: new good payload loaded |
| q_confirmed | output | 1 | Two consecutive good frames were identical |

## Verification
A frame boundary and a synchronized host readout edge can act on the readout register in the same system clock cycle. The bench provokes this by raising `host_sclk` exactly two clock edges before it asserts `sync_mark`, which accounts for the two synchronizer stages. The case is run twice: once partway through a read, and once with the read finished. Mid-read, the bench expects the shift to proceed, no load, no pulse, and the old payload to read out intact. With the read finished, it expects the new payload to appear at bit 79 with the pulse raised, and a complete 80-bit read of the new frame, which shows that the coincident edge was dropped.

// File: rtl/subq_pkg.sv
package subq_pkg;
  localparam int CRC_W = 16;

  // one serial step of a left-shifting CRC with the given polynomial
  function automatic logic [CRC_W-1:0] crc_step(input logic [CRC_W-1:0] cur,
                                                input logic din,
                                                input logic [CRC_W-1:0] poly);
    logic fb;
    fb = cur[CRC_W-1] ^ din;
    return {cur[CRC_W-2:0], 1'b0} ^ (fb ? poly : '0);
  endfunction
endpackage

// File: rtl/subq_collect.sv
module subq_collect
  import subq_pkg::*;
#(
  parameter int               PAYLOAD_W = 80,
  parameter logic [CRC_W-1:0] POLY      = 16'h1021
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 sym_take,
  input  logic                 sym_bit,
  input  logic                 sync_mark,
  output logic                 boundary,
  output logic                 frame_good,
  output logic [PAYLOAD_W-1:0] payload
);
  localparam int FRAME_W = PAYLOAD_W + CRC_W;
  localparam int CNT_W   = $clog2(FRAME_W + 2);

  logic [CNT_W-1:0]   cnt;
  logic [FRAME_W-1:0] shreg;
  logic [CRC_W-1:0]   crc;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt   <= '0;
      shreg <= '0;
      crc   <= '0;
    end else if (sync_mark) begin
      cnt <= '0;
      crc <= '0;
    end else if (sym_take) begin
      shreg <= {shreg[FRAME_W-2:0], sym_bit};
      if (cnt < CNT_W'(PAYLOAD_W))
        crc <= crc_step(crc, sym_bit, POLY);
      if (cnt != CNT_W'(FRAME_W + 1))
        cnt <= cnt + 1'b1;
    end
  end

  assign boundary   = sync_mark && (cnt != '0);
  assign frame_good = (cnt == CNT_W'(FRAME_W)) && (crc == ~shreg[CRC_W-1:0]);
  assign payload    = shreg[FRAME_W-1:CRC_W];
endmodule

// File: rtl/subq_readout.sv
module subq_readout #(
  parameter int PAYLOAD_W   = 80,
  parameter int SYNC_STAGES = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 host_sclk,
  input  logic                 load,
  input  logic [PAYLOAD_W-1:0] load_data,
  output logic                 msb,
  output logic                 mid_read
);
  localparam int RC_W = $clog2(PAYLOAD_W + 1);

  logic [SYNC_STAGES:0]   sq;
  logic                   rise;
  logic [PAYLOAD_W-1:0]   shadow;
  logic [RC_W-1:0]        rcnt;

  always_ff @(posedge clk) begin
    if (!rst_n) sq <= '0;
    else        sq <= {sq[SYNC_STAGES-1:0], host_sclk};
  end

  assign rise = sq[SYNC_STAGES-1] & ~sq[SYNC_STAGES];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      shadow <= '0;
      rcnt   <= '0;
    end else if (load) begin
      shadow <= load_data;
      rcnt   <= '0;
    end else if (rise && rcnt != RC_W'(PAYLOAD_W)) begin
      shadow <= {shadow[PAYLOAD_W-2:0], 1'b0};
      rcnt   <= rcnt + 1'b1;
    end
  end

  assign msb      = shadow[PAYLOAD_W-1];
  assign mid_read = (rcnt != '0) && (rcnt != RC_W'(PAYLOAD_W));
endmodule

// File: rtl/subq_confirm.sv
module subq_confirm #(
  parameter int PAYLOAD_W = 80
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 boundary,
  input  logic                 frame_good,
  input  logic [PAYLOAD_W-1:0] payload,
  output logic                 confirmed
);
  logic [PAYLOAD_W-1:0] prev;
  logic                 have_prev;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prev      <= '0;
      have_prev <= 1'b0;
      confirmed <= 1'b0;
    end else if (boundary) begin
      if (frame_good) begin
        confirmed <= have_prev && (payload == prev);
        prev      <= payload;
        have_prev <= 1'b1;
      end else begin
        confirmed <= 1'b0;
        have_prev <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/subq_frame_reader.sv
module subq_frame_reader
  import subq_pkg::*;
#(
  parameter int               PAYLOAD_W   = 80,
  parameter logic [CRC_W-1:0] POLY        = 16'h1021,
  parameter int               SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sym_valid,
  output logic sym_ready,
  input  logic sym_qbit,
  input  logic sync_mark,
  input  logic host_sclk,
  output logic q_sdata,
  output logic q_crc_ok,
  output logic q_ready_pulse,
  output logic q_confirmed
);
  logic                 boundary, frame_good, mid_read, msb, load;
  logic [PAYLOAD_W-1:0] payload;

  assign sym_ready = 1'b1;

  subq_collect #(.PAYLOAD_W(PAYLOAD_W), .POLY(POLY)) u_collect (
    .clk(clk), .rst_n(rst_n), .sym_take(sym_valid & sym_ready),
    .sym_bit(sym_qbit), .sync_mark(sync_mark),
    .boundary(boundary), .frame_good(frame_good), .payload(payload)
  );

  assign load = boundary && frame_good && !mid_read;

  subq_readout #(.PAYLOAD_W(PAYLOAD_W), .SYNC_STAGES(SYNC_STAGES)) u_readout (
    .clk(clk), .rst_n(rst_n), .host_sclk(host_sclk), .load(load),
    .load_data(payload), .msb(msb), .mid_read(mid_read)
  );

  subq_confirm #(.PAYLOAD_W(PAYLOAD_W)) u_confirm (
    .clk(clk), .rst_n(rst_n), .boundary(boundary), .frame_good(frame_good),
    .payload(payload), .confirmed(q_confirmed)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      q_crc_ok      <= 1'b0;
      q_ready_pulse <= 1'b0;
    end else begin
      if (boundary && !mid_read) q_crc_ok <= frame_good;
      q_ready_pulse <= load;
    end
  end

  assign q_sdata = q_crc_ok & msb;
endmodule

// File: rtl/subq_frame_reader_chk.sv
module subq_frame_reader_chk (
  input logic clk,
  input logic rst_n,
  input logic sync_mark,
  input logic q_crc_ok,
  input logic q_sdata,
  input logic q_ready_pulse,
  input logic q_confirmed
);
  p_pulse_good_r5: assert property (@(posedge clk) disable iff (!rst_n)
    q_ready_pulse |-> q_crc_ok);
  p_pulse_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
    q_ready_pulse |=> !q_ready_pulse);
  p_pulse_after_sync_r5: assert property (@(posedge clk) disable iff (!rst_n)
    q_ready_pulse |-> $past(sync_mark));
  p_gated_data_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !q_crc_ok |-> !q_sdata);
  p_flag_only_at_boundary_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !sync_mark |=> $stable(q_crc_ok));
  p_confirm_only_at_boundary_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !sync_mark |=> $stable(q_confirmed));
endmodule

bind subq_frame_reader subq_frame_reader_chk i_chk (.*);

// File: tb/test_subq_frame_reader.sv
module test_subq_frame_reader;
  logic clk = 1'b0, rst_n = 1'b0;
  logic sym_valid = 1'b0, sym_qbit = 1'b0, sync_mark = 1'b0, host_sclk = 1'b0;
  logic sym_ready, q_sdata, q_crc_ok, q_ready_pulse, q_confirmed;
  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  subq_frame_reader i_subq_frame_reader (.*);

  task automatic check(input string req, input string what,
                       input logic [79:0] act, input logic [79:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  function automatic logic [15:0] ref_crc(input logic [79:0] p);
    logic [15:0] c = '0;
    for (int i = 79; i >= 0; i--) begin
      logic fb = c[15] ^ p[i];
      c = {c[14:0], 1'b0};
      if (fb) c = c ^ 16'h1021;
    end
    return c;
  endfunction

  function automatic logic [95:0] mk_frame(input logic [79:0] p);
    return {p, ~ref_crc(p)};
  endfunction

  // send n bits of a frame (n may be 95..97), idle gap every 7th bit
  task automatic send_bits(input logic [95:0] f, input int n);
    for (int j = 0; j < n; j++) begin
      if (j % 7 == 3) begin sym_valid = 1'b0; @(negedge clk); end
      sym_valid = 1'b1;
      sym_qbit  = (j < 96) ? f[95-j] : 1'b0;
      @(negedge clk);
    end
    sym_valid = 1'b0;
  endtask

  task automatic sync_pulse(input logic with_sym);
    sync_mark = 1'b1; sym_valid = with_sym; sym_qbit = 1'b1;
    @(negedge clk);
    sync_mark = 1'b0; sym_valid = 1'b0;
  endtask

  task automatic host_edge();
    host_sclk = 1'b1; repeat (4) @(negedge clk);
    host_sclk = 1'b0; repeat (4) @(negedge clk);
  endtask

  task automatic read_all(input int first, output logic [79:0] got);
    got = '0;
    for (int i = first; i < 80; i++) begin
      got[79-i] = q_sdata;
      host_edge();
    end
  endtask

  // host edge raised two clock edges before the sync mark: both act together
  task automatic coincide();
    host_sclk = 1'b1;
    @(negedge clk); @(negedge clk);
    sync_mark = 1'b1;
    @(negedge clk);
    sync_mark = 1'b0;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL R6 watchdog actual=hung expected=finished");
      finish_run();
    end
  end

  initial begin
    logic [79:0] pa, pb, got;
    repeat (3) @(negedge clk);
    // R11 reset state, R1 ready
    check("R11", "crc_ok after reset", q_crc_ok, 0);
    check("R11", "confirmed after reset", q_confirmed, 0);
    check("R11", "sdata after reset", q_sdata, 0);
    check("R11", "pulse after reset", q_ready_pulse, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1", "ready high", sym_ready, 1);

    // R2 R4 R5 R6 sweep: walking-one payloads over a background
    for (int k = 0; k < 80; k++) begin
      pa = (80'd1 << k) ^ {5{16'h3A5C}};
      send_bits(mk_frame(pa), 96);
      sync_pulse(1'b0);
      check("R5", "ready pulse", q_ready_pulse, 1);
      check("R4", "crc ok good frame", q_crc_ok, 1);
      check("R10", "confirm differing", q_confirmed, 0);
      read_all(0, got);
      check("R6", "serial payload", got, pa);
      check("R6", "sdata after full read", q_sdata, 0);
    end
    host_edge();
    check("R6", "edge after completion ignored", q_sdata, 0);

    // R10 confirmation sequence
    pa = 80'h1234_5678_9ABC_DEF0_1357;
    pb = 80'hFEDC_BA98_7654_3210_2468;
    send_bits(mk_frame(pa), 96); sync_pulse(1'b0);
    send_bits(mk_frame(pa), 96); sync_pulse(1'b0);
    check("R10", "two equal good frames", q_confirmed, 1);
    send_bits(mk_frame(pb), 96); sync_pulse(1'b0);
    check("R10", "differing frame clears", q_confirmed, 0);
    send_bits(mk_frame(pb) ^ 96'h1, 96); sync_pulse(1'b0);
    check("R10", "bad frame clears", q_confirmed, 0);
    send_bits(mk_frame(pb), 96); sync_pulse(1'b0);
    check("R10", "good after bad not confirmed", q_confirmed, 0);
    send_bits(mk_frame(pb), 96); sync_pulse(1'b0);
    check("R10", "repeat after recovery", q_confirmed, 1);

    // R3 R9: single-bit check-word corruption sweep
    for (int b = 0; b < 16; b++) begin
      send_bits(mk_frame(pa) ^ (96'd1 << b), 96);
      sync_pulse(1'b0);
      check("R3", "corrupted check word", q_crc_ok, 0);
      check("R5", "no pulse on bad frame", q_ready_pulse, 0);
      check("R9", "sdata gated", q_sdata, 0);
    end

    // R3 wrong lengths
    send_bits(mk_frame(pa), 95); sync_pulse(1'b0);
    check("R3", "short frame", q_crc_ok, 0);
    send_bits(mk_frame(pa), 96); sync_pulse(1'b0);
    check("R3", "exact frame", q_crc_ok, 1);
    send_bits(mk_frame(pa), 97); sync_pulse(1'b0);
    check("R3", "long frame", q_crc_ok, 0);

    // R1 R3: second sync mark with a symbol offered is ignored
    send_bits(mk_frame(pb), 96);
    sync_pulse(1'b0);
    sync_pulse(1'b1);
    check("R3", "empty sync keeps flag", q_crc_ok, 1);
    check("R5", "empty sync no pulse", q_ready_pulse, 0);
    send_bits(mk_frame(pa), 96); sync_pulse(1'b0);
    check("R1", "sync-cycle symbol discarded", q_crc_ok, 1);
    read_all(0, got);
    check("R6", "payload after double sync", got, pa);

    // R7 R8: coincidence during a read
    send_bits(mk_frame(pb), 96); sync_pulse(1'b0);
    for (int i = 0; i < 5; i++) host_edge();
    send_bits(mk_frame(pa), 96);
    coincide();
    check("R7", "no pulse mid-read", q_ready_pulse, 0);
    check("R10", "confirm updated mid-read", q_confirmed, 0);
    host_sclk = 1'b0; repeat (4) @(negedge clk);
    check("R7", "flag kept mid-read", q_crc_ok, 1);
    check("R8", "edge applied mid-read", q_sdata, pb[73]);
    read_all(6, got);
    check("R7", "old payload tail intact", got[73:0], {6'd0, pb[73:0]});

    // R8: coincidence with read complete, load wins
    send_bits(mk_frame(pa), 96);
    coincide();
    check("R8", "load wins pulse", q_ready_pulse, 1);
    host_sclk = 1'b0; repeat (4) @(negedge clk);
    check("R8", "first bit after load", q_sdata, pa[79]);
    read_all(0, got);
    check("R8", "edge dropped, full read", got, pa);

    finish_run();
  end
endmodule